// File: doc/BRIEF.md
# Single-Wire Response Frame Receiver

The block listens once on a shared, pulled-up, open-drain wire for a 16-bit reply. A controller strobes `start_i` once per polling slot. The receiver clears its output word. It then checks the wire at a fixed poll spacing for a bounded number of tries, looking for the low level that opens a frame. If the wire never goes low, the block gives up with a one-clock timeout pulse and returns no data.

When a low level is seen, the receiver waits a short settle delay and takes the first sample. It then takes the remaining samples at a fixed bit spacing. Line coding is inverted: a wire pulled low is stored as a 1. Each bit enters at the least significant end, so the first bit received finishes as the most significant bit. After the last bit the word is flagged by a one-clock valid pulse and held until the next accepted strobe.

All timing is derived from `CLK_HZ` and microsecond parameters: a 5 µs poll spacing over 100 tries, a 5 µs settle delay and a 48 µs bit spacing.

Top module: `resp_wire_rx`

## Requirements
- R1: During and after reset, `data_o` is 0 and `valid_o` and `timeout_o` are low.
- R2: A `start_i` sampled high while idle sets `data_o` to 0 on that same clock edge.
- R3: After a start is accepted, the synchronised wire is polled once every POLL_CYC cycles, with POLL_TRIES polls at most. The first poll is one cycle after the accepting edge.
- R4: If every poll sees a high wire, `timeout_o` pulses for exactly one cycle. The pulse comes POLL_TRIES*POLL_CYC+1 cycles after the accepting edge. `data_o` stays 0 and no valid pulse is issued.
- R5: The first sample is taken SETTLE_CYC cycles after the poll that detects the low level. Each later sample follows BIT_CYC cycles after the one before it. Exactly FRAME_BITS samples are taken, and `valid_o` rises on the edge of the last sample.
- R6: A sample of wire level 0 is stored as bit value 1, and a sample of wire level 1 is stored as bit value 0.
- R7: Each sample shifts in at bit 0. The first sample received ends at bit FRAME_BITS-1 and the last at bit 0.
- R8: `valid_o` is a one-cycle pulse and is never high together with `timeout_o`.
- R9: While idle and without a start strobe, `data_o` does not change, whatever the wire does.
- R10: `start_i` is ignored while a poll or a receive is in progress. It neither clears nor restarts the frame.
- R11: `wire_i` passes through a two-flop synchroniser. A low level that is set up before edge k is first visible to a poll at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-listen strobe |
| wire_i | input | 1 | Raw level of the shared response wire |
| data_o | output | FRAME_BITS | Assembled response word |
| valid_o | output | 1 | One-cycle pulse when a full frame is captured |
| timeout_o | output | 1 | One-cycle pulse when no frame started in the wait window |

## Verification
A poll counter that is off by even one cycle moves the timeout pulse away from its exact cycle. The same fault decides whether a wire that falls just before or just after the last poll is caught, so it shows at the end of the first missed slot. A wrong sample or bit counter breaks the frame on its first valid pulse: a bit shifts, the bit order is reversed, a bit is inverted, or the pulse lands outside its narrow window. A state machine that wrongly restarts on a strobe, or fails to clear, leaves a word at `data_o` that does not match the frame just sent or the zero expected after a timeout.

// File: rtl/rwrx_pkg.sv
package rwrx_pkg;
  typedef enum logic [1:0] {
    RW_IDLE = 2'd0,
    RW_HUNT = 2'd1,
    RW_RECV = 2'd2
  } rw_state_e;
endpackage

// File: rtl/rwrx_sync.sv
module rwrx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g > 0) ? g - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rwrx_shreg.sv
module rwrx_shreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         line_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clr_i)   q_o <= '0;
    else if (shift_i) q_o <= {q_o[W-2:0], ~line_i}; // low wire = 1
  end
endmodule

// File: rtl/resp_wire_rx.sv
module resp_wire_rx
  import rwrx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned POLL_US     = 5,
  parameter int unsigned POLL_TRIES  = 100,
  parameter int unsigned SETTLE_US   = 5,
  parameter int unsigned BIT_US      = 48,
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  wire_i,
  output logic [FRAME_BITS-1:0] data_o,
  output logic                  valid_o,
  output logic                  timeout_o
);
  localparam int unsigned CYC_US     = CLK_HZ / 1_000_000;
  localparam int unsigned POLL_CYC   = (CYC_US * POLL_US   > 0) ? CYC_US * POLL_US   : 1;
  localparam int unsigned SETTLE_CYC = (CYC_US * SETTLE_US > 0) ? CYC_US * SETTLE_US : 1;
  localparam int unsigned BIT_CYC    = (CYC_US * BIT_US    > 0) ? CYC_US * BIT_US    : 1;
  localparam int unsigned WAIT_MAX   = (SETTLE_CYC > BIT_CYC) ? SETTLE_CYC : BIT_CYC;
  localparam int unsigned PCW        = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int unsigned TW         = $clog2(POLL_TRIES + 1);
  localparam int unsigned WW         = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;
  localparam int unsigned BW         = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  rw_state_e      st_q;
  logic [PCW-1:0] pcnt_q;
  logic [TW-1:0]  tries_q;
  logic [WW-1:0]  wait_q;
  logic [BW-1:0]  bits_q;
  logic           valid_q, tout_q;
  logic           wire_s;

  logic busy, in_recv, poll_now, samp_en, clr_en;

  rwrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wire_i),
    .q_o   (wire_s)
  );

  assign busy     = (st_q != RW_IDLE);
  assign in_recv  = (st_q == RW_RECV);
  assign poll_now = (st_q == RW_HUNT) && (pcnt_q == '0);
  assign samp_en  = in_recv && (wait_q == '0);
  assign clr_en   = (st_q == RW_IDLE) && start_i;

  rwrx_shreg #(.W(FRAME_BITS)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_en),
    .shift_i(samp_en),
    .line_i (wire_s),
    .q_o    (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RW_IDLE;
      pcnt_q  <= '0;
      tries_q <= '0;
      wait_q  <= '0;
      bits_q  <= '0;
      valid_q <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      tout_q  <= 1'b0;
      unique case (st_q)
        RW_IDLE: begin
          if (start_i) begin
            st_q    <= RW_HUNT;
            pcnt_q  <= '0;
            tries_q <= '0;
          end
        end
        RW_HUNT: begin
          pcnt_q <= (pcnt_q == PCW'(POLL_CYC - 1)) ? '0 : pcnt_q + 1'b1;
          if (poll_now) begin
            if (tries_q == TW'(POLL_TRIES)) begin
              tout_q <= 1'b1;
              st_q   <= RW_IDLE;
            end else if (!wire_s) begin
              st_q   <= RW_RECV;
              wait_q <= WW'(SETTLE_CYC - 1);
              bits_q <= '0;
            end else begin
              tries_q <= tries_q + 1'b1;
            end
          end
        end
        RW_RECV: begin
          if (samp_en) begin
            wait_q <= WW'(BIT_CYC - 1);
            if (bits_q == BW'(FRAME_BITS - 1)) begin
              valid_q <= 1'b1;
              st_q    <= RW_IDLE;
            end else begin
              bits_q <= bits_q + 1'b1;
            end
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        default: st_q <= RW_IDLE;
      endcase
    end
  end

  assign valid_o   = valid_q;
  assign timeout_o = tout_q;
endmodule

// File: rtl/rwrx_chk.sv
module rwrx_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [N-1:0] data_o,
  input logic         valid_o,
  input logic         timeout_o,
  input logic         busy_i,
  input logic         hunt_i,
  input logic         recv_i,
  input logic         samp_i
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_VALID_NOT_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && timeout_o)); // R8
  AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R4
  AST_TIMEOUT_AFTER_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(hunt_i)); // R4
  AST_TIMEOUT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (data_o == '0)); // R4
  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i) |=> (data_o == '0)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(data_o)); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recv_i && !samp_i && start_i) |=> ($stable(data_o) && recv_i)); // R10
  AST_VALID_FROM_RECV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(recv_i && samp_i)); // R5
endmodule

bind resp_wire_rx rwrx_chk #(.N(FRAME_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .timeout_o(timeout_o),
  .busy_i   (busy),
  .hunt_i   (st_q == rwrx_pkg::RW_HUNT),
  .recv_i   (in_recv),
  .samp_i   (samp_en)
);

// File: tb/sim_resp_wire_rx.sv
`timescale 1ns/1ps
module sim_resp_wire_rx;
  localparam int P = 5, T = 100, S = 5, B = 48, N = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, line = 1'b1;
  logic [N-1:0] data;
  logic valid, tout;

  int total = 0, fails = 0;
  int cyc = 0, vcnt = 0, tcnt = 0, vcyc = 0, tcyc = 0, vdup = 0, vboth = 0;
  logic prev_v = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  resp_wire_rx #(.CLK_HZ(1_000_000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wire_i(line),
    .data_o(data), .valid_o(valid), .timeout_o(tout)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (valid) begin vcnt++; vcyc = cyc; end
    if (tout) begin tcnt++; tcyc = cyc; end
    if (valid && prev_v) vdup++;
    if (valid && tout) vboth++;
    prev_v = valid;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // start strobe on one negedge; returns the cycle count seen there
  task automatic strobe(output int c0);
    @(negedge clk);
    c0 = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic frame(input logic [N-1:0] w, input int dly, input bit mid_start);
    int c0, l, v0, t0;
    v0 = vcnt; t0 = tcnt;
    strobe(c0);
    repeat (dly) @(negedge clk);
    l = cyc;
    for (int i = N - 1; i >= 0; i--) begin
      line = ~w[i];
      for (int j = 0; j < B; j++) begin
        if (mid_start && i == 8) start = (j == 0);
        @(negedge clk);
      end
    end
    start = 1'b0;
    line = 1'b1;
    repeat (4) @(negedge clk);
    chk(vcnt == v0 + 1, "R5 one valid per frame", vcnt, v0 + 1);
    chk(data == w, mid_start ? "R10 word after busy strobe" : "R6 R7 word", data, w);
    chk(vcyc >= l + 3 + S + (N - 1) * B && vcyc <= l + 3 + (P - 1) + S + (N - 1) * B,
        "R5 valid timing", vcyc - l, 3 + S + (N - 1) * B);
    chk(tcnt == t0, "R8 no timeout on frame", tcnt, t0);
  endtask

  initial begin
    int c0, t0, v0, ref_hold;
    logic [N-1:0] w;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk(data == '0 && !valid && !tout, "R1 in reset", {data, valid, tout}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(data == '0 && !valid && !tout, "R1 after reset", {data, valid, tout}, 0);

    // timeout with exact latency
    t0 = tcnt; v0 = vcnt;
    strobe(c0);
    repeat (T * P + 10) @(negedge clk);
    chk(tcnt == t0 + 1, "R4 timeout count", tcnt, t0 + 1);
    chk(tcyc == c0 + 2 + T * P, "R3 R4 timeout cycle", tcyc - c0, 2 + T * P);
    chk(vcnt == v0, "R4 no valid on timeout", vcnt, v0);

    // inverted coding, MSB-first, patterns and delays
    frame(16'h8000, 0, 0);
    frame(16'hFFFF, 3, 0);
    frame(16'h8001, 17, 0);
    frame(16'hAAAA, 120, 0);
    frame(16'hC35A, 251, 0);
    for (int k = 1; k <= 10; k++) begin
      w = 16'h8000 | 16'((k * 40503) ^ (k << 7));
      frame(w, (k * 37) % 400, 0);
    end

    // hold while idle, wire toggling
    ref_hold = data; v0 = vcnt; t0 = tcnt; lf = 16'hACE1;
    for (int i = 0; i < 150; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      line = lf[0];
      @(negedge clk);
    end
    line = 1'b1;
    repeat (4) @(negedge clk);
    chk(data == N'(ref_hold), "R9 data held idle", data, ref_hold);
    chk(vcnt == v0 && tcnt == t0, "R9 no pulses idle", vcnt + tcnt, v0 + t0);

    // clear on start
    strobe(c0);
    chk(data == '0, "R2 clear on start", data, 0);
    repeat (T * P + 10) @(negedge clk);
    chk(data == '0, "R4 data zero after timeout", data, 0);

    // start strobe mid-frame ignored
    frame(16'hB7E1, 40, 1);
    frame(16'h9249, 9, 1);

    // synchroniser boundary: low just in time for last poll
    strobe(c0);
    while (cyc < c0 - 1 + (T - 1) * P) @(negedge clk);
    w = 16'hE00F; v0 = vcnt; t0 = tcnt;
    for (int i = N - 1; i >= 0; i--) begin
      line = ~w[i];
      repeat (B) @(negedge clk);
    end
    line = 1'b1;
    repeat (4) @(negedge clk);
    chk(vcnt == v0 + 1 && tcnt == t0, "R11 caught at last poll", vcnt, v0 + 1);
    chk(data == w, "R11 word at last poll", data, w);

    // one cycle later: missed, timeout
    strobe(c0);
    while (cyc < c0 + (T - 1) * P) @(negedge clk);
    v0 = vcnt; t0 = tcnt;
    for (int i = N - 1; i >= 0; i--) begin
      line = ~w[i];
      repeat (B) @(negedge clk);
    end
    line = 1'b1;
    repeat (4) @(negedge clk);
    chk(tcnt == t0 + 1 && vcnt == v0, "R11 missed after last poll", tcnt, t0 + 1);
    chk(data == '0, "R4 no data after miss", data, 0);

    chk(vdup == 0, "R8 valid single cycle", vdup, 0);
    chk(vboth == 0, "R8 valid and timeout exclusive", vboth, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule